// File: doc/BRIEF.md
# NAND Unique Identifier Fetch Sequencer

This block runs the full exchange needed to pull a 128-bit factory identifier out of a NAND device over an 8-bit asynchronous bus. When the host pulses `start`, the sequencer selects the device and latches the identifier-read opcode (0xED) with CLE. It then latches a single zero address byte with ALE. After a programmable settling delay it waits for the device to leave its busy state, and then strobes data bytes out with RE#.

The device stores sixteen back-to-back 32-byte records. Each record is the 16 identifier bytes followed by their bitwise inverse. The sequencer checks each record as it streams in and stops at the first one whose halves are exact complements. It then presents that identifier with a valid flag. If none of the sixteen records checks out, it reports an error instead. Bus strobe widths are set in system clocks by parameters, so the same block fits any timing mode the device supports.

Top module: `nand_uid_reader`

## Requirements
- R1: After an accepted start, exactly one command write occurs with CLE high and DQ driven to 0xED, followed by exactly one address write with ALE high and DQ driven to 0x00; each WE# low phase lasts T_WE_LO clocks and the WE# high phase between them lasts T_WE_HI clocks; no further WE# pulse occurs in the operation (so no status read is ever issued).
- R2: After the address write, no RE# pulse is issued until T_WB clocks have elapsed and the synchronized ready/busy line then reads ready (high).
- R3: Each RE# low phase lasts T_RE_LO clocks and each RE# high phase between reads lasts T_RE_HI clocks; the data byte is captured at the clock edge where RE# rises.
- R4: A record is 32 bytes; record byte i (0..15) lands in `uid[8*i+7:8*i]` and the record passes only if record byte 16+i XOR record byte i equals 0xFF for every i.
- R5: Reading stops after the first passing record (32*(k+1) bytes read when record k is the first to pass); `uid_valid` is then set and `uid` holds that record's identifier.
- R6: If all sixteen records fail, exactly 512 bytes are read, `uid_err` is set, `uid_valid` is clear and `uid` reads zero.
- R7: CE# is low from the command write until after the last data byte and high when idle and when `done` is raised; CE# is low whenever WE# or RE# is low.
- R8: `done` is a single-clock pulse during which exactly one of `uid_valid` and `uid_err` is set; both flags hold their value until the next accepted start, which clears them in the following clock.
- R9: A `start` pulse while an operation is in progress is ignored: the running operation reads the same number of bytes and gives the same result.
- R10: While and after reset: CE#, WE#, RE# high, CLE, ALE, DQ output enable, `done`, `uid_valid`, `uid_err` low.
- R11: CLE and ALE are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin one identifier fetch |
| done | output | 1 | One-clock completion pulse |
| uid_valid | output | 1 | A checked identifier is on `uid` |
| uid_err | output | 1 | No record passed the complement check |
| uid | output | 128 | Identifier, byte 0 in bits 7:0 |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto DQ |
| nand_dq_oe | output | 1 | DQ output enable |
| nand_dq_in | input | 8 | Byte read from DQ |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The hardest outcomes to reach from the ports are a pass on the very last record and the all-fail error, since both need fifteen or sixteen corrupted records in front of them. The bench's device model builds each 512-byte image with a chosen count of leading records broken by a single flipped bit. The flipped bit's position moves between the identifier half and the complement half. A fully erased image (all 0xFF) fails in a different way. A second start pulse is injected in the middle of a long read to show it is ignored.

// File: rtl/nuid_pkg.sv
package nuid_pkg;
  localparam logic [7:0] OP_READ_UID = 8'hED;
  localparam logic [7:0] UID_ADDR    = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_ADR_LO,
    ST_ADR_HI,
    ST_WB,
    ST_BUSY,
    ST_RD_LO,
    ST_RD_HI,
    ST_FIN
  } seq_state_t;
endpackage

// File: rtl/nuid_sync.sv
module nuid_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nuid_timer.sv
module nuid_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/nuid_rec_check.sv
module nuid_rec_check #(
  parameter int ID_BYTES = 16,
  parameter int COPIES   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_in,
  output logic                    pass,
  output logic                    fail,
  output logic [8*ID_BYTES-1:0]   uid_flat
);
  localparam int REC_BYTES = 2 * ID_BYTES;
  localparam int PW = $clog2(REC_BYTES);
  localparam int IW = $clog2(ID_BYTES);
  localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;

  logic [PW-1:0] pos;
  logic [CW-1:0] rec;
  logic          rec_ok;
  logic [7:0]    id_mem [ID_BYTES];

  logic          in_comp;
  logic [PW-1:0] off;
  logic [IW-1:0] ix;
  logic          byte_ok;
  logic          ok_now;
  logic          last_byte;

  assign in_comp   = (pos >= PW'(ID_BYTES));
  assign off       = in_comp ? (pos - PW'(ID_BYTES)) : pos;
  assign ix        = off[IW-1:0];
  assign byte_ok   = ((byte_in ^ id_mem[ix]) == 8'hFF);
  assign ok_now    = rec_ok & byte_ok;
  assign last_byte = (pos == PW'(REC_BYTES - 1));

  // identifier half of the current record, one write port
  always_ff @(posedge clk) begin
    if (byte_vld && !in_comp) id_mem[ix] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos    <= '0;
      rec    <= '0;
      rec_ok <= 1'b1;
      pass   <= 1'b0;
      fail   <= 1'b0;
    end else if (byte_vld) begin
      if (in_comp) rec_ok <= ok_now;
      if (last_byte) begin
        pos    <= '0;
        rec    <= rec + 1'b1;
        rec_ok <= 1'b1;
        if (ok_now)                        pass <= 1'b1;
        else if (rec == CW'(COPIES - 1))   fail <= 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_flat
    assign uid_flat[8*g +: 8] = id_mem[g];
  end

  // R6: a verdict is either pass or fail, never both
  a_r6_verdict_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  // R5: the sequencer delivers no byte once a verdict exists
  a_r5_quiet_after_verdict: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> !byte_vld);
endmodule

// File: rtl/nand_uid_reader.sv
module nand_uid_reader
  import nuid_pkg::*;
#(
  parameter int ID_BYTES = 16,
  parameter int COPIES   = 16,
  parameter int TMR_W    = 8,
  parameter int T_WE_LO  = 2,
  parameter int T_WE_HI  = 2,
  parameter int T_RE_LO  = 3,
  parameter int T_RE_HI  = 2,
  parameter int T_WB     = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  output logic                   done,
  output logic                   uid_valid,
  output logic                   uid_err,
  output logic [8*ID_BYTES-1:0]  uid,
  output logic                   nand_ce_n,
  output logic                   nand_cle,
  output logic                   nand_ale,
  output logic                   nand_we_n,
  output logic                   nand_re_n,
  output logic [7:0]             nand_dq_out,
  output logic                   nand_dq_oe,
  input  logic [7:0]             nand_dq_in,
  input  logic                   nand_rb_n
);
  seq_state_t state, nxt;

  logic             rb_sync;
  logic             tmr_exp;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             byte_vld;
  logic             accept;
  logic             rc_pass, rc_fail;
  logic [8*ID_BYTES-1:0] rc_uid;

  nuid_sync #(.RST_VAL(1'b0)) i_rb_sync (
    .clk (clk),
    .rst (rst),
    .d   (nand_rb_n),
    .q   (rb_sync)
  );

  nuid_timer #(.W(TMR_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  assign accept   = (state == ST_IDLE) && start;
  assign byte_vld = (state == ST_RD_LO) && tmr_exp;

  nuid_rec_check #(.ID_BYTES(ID_BYTES), .COPIES(COPIES)) i_check (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .byte_vld (byte_vld),
    .byte_in  (nand_dq_in),
    .pass     (rc_pass),
    .fail     (rc_fail),
    .uid_flat (rc_uid)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start)   nxt = ST_CMD_LO;
      ST_CMD_LO: if (tmr_exp) nxt = ST_CMD_HI;
      ST_CMD_HI: if (tmr_exp) nxt = ST_ADR_LO;
      ST_ADR_LO: if (tmr_exp) nxt = ST_ADR_HI;
      ST_ADR_HI: if (tmr_exp) nxt = ST_WB;
      ST_WB:     if (tmr_exp) nxt = ST_BUSY;
      ST_BUSY:   if (rb_sync) nxt = ST_RD_LO;
      ST_RD_LO:  if (tmr_exp) nxt = ST_RD_HI;
      ST_RD_HI:  if (tmr_exp) nxt = (rc_pass || rc_fail) ? ST_FIN : ST_RD_LO;
      ST_FIN:                 nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_CMD_LO, ST_ADR_LO: tmr_val = TMR_W'(T_WE_LO - 1);
      ST_CMD_HI, ST_ADR_HI: tmr_val = TMR_W'(T_WE_HI - 1);
      ST_WB:                tmr_val = TMR_W'(T_WB - 1);
      ST_RD_LO:             tmr_val = TMR_W'(T_RE_LO - 1);
      ST_RD_HI:             tmr_val = TMR_W'(T_RE_HI - 1);
      default:              tmr_val = '0;
    endcase
  end

  assign tmr_load = (nxt != state);

  // every pin is a register loaded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      nand_ce_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_we_n   <= 1'b1;
      nand_re_n   <= 1'b1;
      nand_dq_out <= 8'h00;
      nand_dq_oe  <= 1'b0;
      done        <= 1'b0;
      uid_valid   <= 1'b0;
      uid_err     <= 1'b0;
      uid         <= '0;
    end else begin
      state       <= nxt;
      nand_ce_n   <= (nxt == ST_IDLE) || (nxt == ST_FIN);
      nand_cle    <= (nxt == ST_CMD_LO) || (nxt == ST_CMD_HI);
      nand_ale    <= (nxt == ST_ADR_LO) || (nxt == ST_ADR_HI);
      nand_we_n   <= !((nxt == ST_CMD_LO) || (nxt == ST_ADR_LO));
      nand_re_n   <= (nxt != ST_RD_LO);
      nand_dq_oe  <= (nxt == ST_CMD_LO) || (nxt == ST_CMD_HI) ||
                     (nxt == ST_ADR_LO) || (nxt == ST_ADR_HI);
      nand_dq_out <= ((nxt == ST_CMD_LO) || (nxt == ST_CMD_HI)) ? OP_READ_UID : UID_ADDR;
      done        <= (nxt == ST_FIN);
      if (accept) begin
        uid_valid <= 1'b0;
        uid_err   <= 1'b0;
        uid       <= '0;
      end else if (nxt == ST_FIN) begin
        uid_valid <= rc_pass;
        uid_err   <= !rc_pass;
        uid       <= rc_pass ? rc_uid : '0;
      end
    end
  end

  // R11: command and address latches are exclusive
  a_r11_cle_ale_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  // R7: any strobe happens only with the device selected
  a_r7_ce_covers_strobes: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R7: chip released when completion is signalled
  a_r7_ce_released_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> nand_ce_n);

  // R8: completion carries exactly one verdict
  a_r8_done_verdict: assert property (@(posedge clk) disable iff (rst)
    done |-> (uid_valid ^ uid_err));

  // R8: completion is a single-clock pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: the bus is driven whenever a write strobe is low
  a_r1_we_drives_bus: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_dq_oe);

  // R2: no read strobe while the synchronized line still says busy
  a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BUSY && !rb_sync) |=> nand_re_n);

  // R3: each captured byte coincides with a rising read strobe
  a_r3_capture_on_re_rise: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> $rose(nand_re_n));
endmodule

// File: tb/test_nand_uid_reader.sv
module test_nand_uid_reader;
  localparam int CLK_PERIOD = 10;
  localparam int P_WE_LO = 2;
  localparam int P_WE_HI = 2;
  localparam int P_RE_LO = 3;
  localparam int P_RE_HI = 2;
  localparam int P_WB    = 4;
  localparam int BUSY_CYC = 20;

  typedef struct packed {
    logic [7:0] seed;
    logic [4:0] nbad;
    logic       erased;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'h11, 5'd0,  1'b0},
    '{8'h3C, 5'd1,  1'b0},
    '{8'h7E, 5'd5,  1'b0},
    '{8'hA2, 5'd15, 1'b0},
    '{8'h05, 5'd16, 1'b0},
    '{8'h99, 5'd0,  1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, uid_valid, uid_err;
  logic [127:0] uid;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out, nand_dq_in;
  logic nand_rb_n;

  int n_checks = 0;
  int n_fail   = 0;
  longint cyc_total = 0;
  bit finished = 0;

  // device model state
  logic [7:0] mem [512];
  int  ptr = 0;
  int  busy_cnt = 0;
  int  we_pulses = 0;
  logic [7:0] cmd_seen = 8'h00, addr_seen = 8'hAA;
  int  we_lo_run = 0, we_hi_run = 0, re_lo_run = 0, re_hi_run = 0;
  int  we_lo_min = 999, we_lo_max = 0, we_hi_w = -1;
  int  re_lo_min = 999, re_lo_max = 0, re_hi_min = 999, re_hi_max = 0;
  int  re_early = 0, ce_bad = 0, cle_ale_bad = 0, re_pulses = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign nand_rb_n  = (busy_cnt == 0);
  assign nand_dq_in = mem[ptr[8:0]];

  nand_uid_reader #(
    .T_WE_LO(P_WE_LO), .T_WE_HI(P_WE_HI),
    .T_RE_LO(P_RE_LO), .T_RE_HI(P_RE_HI), .T_WB(P_WB)
  ) i_nand_uid_reader (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .uid_valid(uid_valid), .uid_err(uid_err), .uid(uid),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
  );

  // device model, observed away from the active edge
  always @(negedge clk) begin
    if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
    if (nand_cle && nand_ale) cle_ale_bad++;
    if ((!nand_we_n || !nand_re_n) && nand_ce_n) ce_bad++;
    // write strobe
    if (!nand_we_n) begin
      if (prev_we && we_pulses > 0) we_hi_w = we_hi_run;
      we_lo_run++;
    end else begin
      if (!prev_we) begin
        if (we_lo_run < we_lo_min) we_lo_min = we_lo_run;
        if (we_lo_run > we_lo_max) we_lo_max = we_lo_run;
        we_pulses++;
        if (nand_cle) cmd_seen = nand_dq_out;
        if (nand_ale) begin
          addr_seen = nand_dq_out;
          busy_cnt = BUSY_CYC;
        end
        we_hi_run = 0;
      end
      we_lo_run = 0;
      we_hi_run++;
    end
    // read strobe
    if (!nand_re_n) begin
      if (prev_re) begin
        if (!nand_rb_n) re_early++;
        if (re_pulses > 0) begin
          if (re_hi_run < re_hi_min) re_hi_min = re_hi_run;
          if (re_hi_run > re_hi_max) re_hi_max = re_hi_run;
        end
        re_pulses++;
      end
      re_lo_run++;
    end else begin
      if (!prev_re) begin
        if (re_lo_run < re_lo_min) re_lo_min = re_lo_run;
        if (re_lo_run > re_lo_max) re_lo_max = re_lo_run;
        ptr++;
        re_hi_run = 0;
      end
      re_lo_run = 0;
      re_hi_run++;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] id_byte(input logic [7:0] seed, input int i);
    return 8'(seed * 8'd29 + 8'(i) * 8'd13) ^ 8'h5A;
  endfunction

  task automatic model_clear();
    ptr = 0; busy_cnt = 0; we_pulses = 0; re_pulses = 0;
    cmd_seen = 8'h00; addr_seen = 8'hAA;
    we_lo_min = 999; we_lo_max = 0; we_hi_w = -1;
    re_lo_min = 999; re_lo_max = 0; re_hi_min = 999; re_hi_max = 0;
    re_early = 0; ce_bad = 0; cle_ale_bad = 0;
  endtask

  task automatic build_image(input vec_t v);
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < 16; i++) begin
        mem[r*32 + i]      = v.erased ? 8'hFF : id_byte(v.seed, i);
        mem[r*32 + 16 + i] = v.erased ? 8'hFF : ~id_byte(v.seed, i);
      end
      if (!v.erased && r < int'(v.nbad)) begin
        int p;
        p = (int'(v.seed) + r*5) % 32;
        mem[r*32 + p] = mem[r*32 + p] ^ (8'h01 << (r % 8));
      end
    end
  endtask

  task automatic run_case(input vec_t v, input bit poke);
    logic [127:0] exp_uid;
    bit exp_ok;
    int exp_bytes;
    int waited;
    exp_ok    = !v.erased && (v.nbad < 16);
    exp_bytes = exp_ok ? 32 * (int'(v.nbad) + 1) : 512;
    for (int i = 0; i < 16; i++) exp_uid[8*i +: 8] = exp_ok ? id_byte(v.seed, i) : 8'h00;
    build_image(v);
    @(negedge clk);
    model_clear();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: flags cleared one clock after an accepted start
    chk(!uid_valid && !uid_err, "R8 flags cleared by start", {uid_valid, uid_err}, 0);
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
      start = (poke && waited == 200);  // R9: stray start mid-read
    end
    start = 1'b0;
    chk(done, "R8 done reached", done, 1);
    chk(uid_valid == exp_ok && uid_err == !exp_ok, "R5/R6 verdict",
        {uid_valid, uid_err}, {exp_ok, !exp_ok});
    chk(uid == exp_uid, exp_ok ? "R4 R5 identifier" : "R6 identifier zero", uid, exp_uid);
    chk(ptr == exp_bytes, exp_ok ? "R5 bytes read" : "R6 bytes read", ptr, exp_bytes);
    chk(we_pulses == 2 && cmd_seen == 8'hED && addr_seen == 8'h00,
        "R1 command/address writes", {we_pulses[7:0], cmd_seen, addr_seen}, {8'd2, 8'hED, 8'h00});
    chk(we_lo_min == P_WE_LO && we_lo_max == P_WE_LO && we_hi_w == P_WE_HI,
        "R1 WE widths", {we_lo_min[7:0], we_lo_max[7:0], we_hi_w[7:0]},
        {8'(P_WE_LO), 8'(P_WE_LO), 8'(P_WE_HI)});
    chk(re_early == 0, "R2 no read while busy", re_early, 0);
    chk(re_lo_min == P_RE_LO && re_lo_max == P_RE_LO, "R3 RE low width",
        {re_lo_min[7:0], re_lo_max[7:0]}, {8'(P_RE_LO), 8'(P_RE_LO)});
    chk(re_hi_min == P_RE_HI && re_hi_max == P_RE_HI, "R3 RE high width",
        {re_hi_min[7:0], re_hi_max[7:0]}, {8'(P_RE_HI), 8'(P_RE_HI)});
    chk(nand_ce_n && ce_bad == 0, "R7 chip enable", {nand_ce_n, ce_bad[7:0]}, {1'b1, 8'd0});
    chk(cle_ale_bad == 0, "R11 CLE/ALE exclusive", cle_ale_bad, 0);
    @(negedge clk);
    chk(!done, "R8 done single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(uid_valid == exp_ok && uid_err == !exp_ok, "R8 flags held",
        {uid_valid, uid_err}, {exp_ok, !exp_ok});
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000 && !finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R10 strobes idle high",
        {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R10 latches idle low",
        {nand_cle, nand_ale, nand_dq_oe}, 3'b000);
    chk(!done && !uid_valid && !uid_err, "R10 status low",
        {done, uid_valid, uid_err}, 3'b000);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n, "R7 idle without start", {nand_ce_n, nand_we_n}, 2'b11);

    for (int k = 0; k < NVEC; k++) run_case(VECS[k], 1'b0);

    // R9: stray start during a long read (first pass on record 10)
    run_case('{8'h42, 5'd9, 1'b0}, 1'b1);
    // R6 after R5: error case directly after a pass, flags must flip
    run_case('{8'hC3, 5'd16, 1'b0}, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule